// File: doc/BRIEF.md
# DCT-Domain Watermark Bit Inserter

This block embeds one 2x2 tile of a binary watermark into one 8x8 host-image block that has already been transformed to the DCT domain. The block receives the four lowest-frequency coefficients of the block: the DC term c00 and the three AC terms c01, c10 and c11. It also receives the four watermark bits that belong to that block. Each coefficient is scaled by (1 + alpha) or by (1 - alpha). The watermark bit picks the sign. The coefficient type picks alpha: a weak strength is used for the DC term and a stronger one for the AC terms.

A one-cycle `start` strobe loads a coefficient set and its bits. Some cycles later the block returns the four modified coefficients together with a one-cycle `done` strobe. The `PARALLEL` parameter chooses between two variants:
- `PARALLEL = 0` is the compact variant. It has one shared multiply/add-subtract lane and handles one coefficient per cycle, so a block takes four cycles.
- `PARALLEL = 1` has two lanes and takes two cycles.

A new `start` may be issued in the final compute cycle of a running block, so that blocks stream back to back.

Top module: `wm_inserter`

## Requirements
- R1: While reset is asserted (synchronous, active low), `done_o` is 0 and all four coefficient outputs are 0.
- R2: Watermark bit `wm_i[0]` is paired with c00, `wm_i[1]` with c01, `wm_i[2]` with c10 and `wm_i[3]` with c11. Only these four coefficients are modified.
- R3: For each coefficient c, with strength a in Q1.15, the offset is d = (c*a + 16384) >>> 15, where >>> is an arithmetic shift (round to nearest). The result is c + d when the paired bit is 1 and c - d when it is 0.
- R4: The strength is 655 (about 0.02) for c00 and 3277 (about 0.1) for c01, c10 and c11. For example, c = 10000 with bit 1 gives 10200 for c00 and 11000 for an AC term.
- R5: Each result is saturated to the signed 16-bit range [-32768, 32767].
- R6: `done_o` is a single-cycle pulse. It is high in the cycle that follows the 4th clock edge after the edge that accepted `start` (the 2nd edge when `PARALLEL = 1`). The four outputs hold the block's results in that cycle.
- R7: A `start` seen while a block is in progress is ignored, except in the block's final compute cycle. There it is accepted, and the next block follows back to back with no idle cycle.
- R8: Outside a running block, the outputs keep their last values.
- R9: The coefficients and bits are captured only at an accepted `start`. Later changes on those inputs do not affect the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load a coefficient set and begin |
| c00_i | input | 16 | DC coefficient, signed |
| c01_i | input | 16 | AC coefficient (0,1), signed |
| c10_i | input | 16 | AC coefficient (1,0), signed |
| c11_i | input | 16 | AC coefficient (1,1), signed |
| wm_i | input | 4 | Watermark tile bits, one per coefficient |
| c00_o | output | 16 | Modified DC coefficient |
| c01_o | output | 16 | Modified AC coefficient (0,1) |
| c10_o | output | 16 | Modified AC coefficient (1,0) |
| c11_o | output | 16 | Modified AC coefficient (1,1) |
| done_o | output | 1 | One-cycle strobe: outputs valid |

## Verification
Two events can fall in the same cycle: a new `start` and the final compute step of the previous block, which is also the edge that raises `done_o`. The bench provokes this in both variants by pulsing `start` with fresh data exactly one cycle before the expected `done_o`. It then checks two things: the first `done_o` carries the old block's results, and a second `done_o` follows one full latency later with the new results. A `start` issued at an earlier step of a running block is also tested. That start must produce no extra strobe and must not disturb the held results.

// File: rtl/wm_pkg.sv
// Package: shared constants and types for the watermark inserter.
// Assumes exactly four coefficients per block, indexed 0..3 in the order
// DC, AC(0,1), AC(1,0), AC(1,1); index 0 is the only DC term.
package wm_pkg;

    localparam int unsigned NUM_COEF = 4;
    localparam int unsigned IDX_W    = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_DC   = 2'd0,
        IDX_AC01 = 2'd1,
        IDX_AC10 = 2'd2,
        IDX_AC11 = 2'd3
    } coef_idx_e;

endpackage

// File: rtl/wm_seq.sv
// Module: wm_seq
// Step sequencer for the inserter. It accepts start when idle or in the final
// step, walks step 0..STEPS-1 and raises done for one cycle after the last
// step. Assumes STEPS >= 2.
module wm_seq #(
    parameter int unsigned STEPS = 4,
    localparam int unsigned STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic              last,
    output logic [STEP_W-1:0] step,
    output logic              done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    // Decode the final step and whether a start is taken this cycle.
    always_comb begin
        last   = busy && (step == LAST_STEP);
        accept = start && (!busy || last);
    end

    // Advance the step counter and produce the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                busy <= 1'b1;
                step <= '0;
            end else if (last) begin
                busy <= 1'b0;
                step <= '0;
            end else if (busy) begin
                step <= step + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wm_strength_sel.sv
// Module: wm_strength_sel
// Strength multiplexer: returns the DC strength for coefficient index 0 and
// the AC strength for every other index. Both strengths are Q1.15 values.
module wm_strength_sel
    import wm_pkg::*;
#(
    parameter int unsigned ALPHA_W  = 16,
    parameter int unsigned ALPHA_DC = 655,
    parameter int unsigned ALPHA_AC = 3277
) (
    input  logic [IDX_W-1:0]   idx,
    output logic [ALPHA_W-1:0] alpha
);

    // Pick the strength by coefficient class.
    always_comb begin
        alpha = (coef_idx_e'(idx) == IDX_DC) ? ALPHA_W'(ALPHA_DC) : ALPHA_W'(ALPHA_AC);
    end

endmodule

// File: rtl/wm_scale_lane.sv
// Module: wm_scale_lane
// One arithmetic lane. It computes c +/- round(c * alpha) and saturates the
// result to the coefficient width. alpha is non-negative with FRAC_W
// fraction bits and assumed below 1.0, so the offset fits in COEF_W+1 bits.
module wm_scale_lane #(
    parameter int unsigned COEF_W  = 16,
    parameter int unsigned ALPHA_W = 16,
    parameter int unsigned FRAC_W  = 15
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic        [ALPHA_W-1:0] alpha,
    input  logic                      add,
    output logic signed [COEF_W-1:0] res
);

    localparam int unsigned PROD_W = COEF_W + ALPHA_W + 1;
    localparam int unsigned SUM_W  = COEF_W + 2;
    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) << (FRAC_W - 1);
    localparam logic signed [SUM_W-1:0]  MAX_S = (SUM_W'(1) << (COEF_W - 1)) - SUM_W'(1);
    localparam logic signed [SUM_W-1:0]  MIN_S = -(SUM_W'(1) << (COEF_W - 1));

    logic signed [PROD_W-1:0] c_w, a_w, prod, shifted;
    logic signed [COEF_W:0]   delta;
    logic signed [SUM_W-1:0]  sum;

    // Multiply, round to nearest and scale back to integer units.
    always_comb begin
        c_w     = PROD_W'(coef);
        a_w     = PROD_W'($signed({1'b0, alpha}));
        prod    = c_w * a_w;
        shifted = (prod + HALF) >>> FRAC_W;
        delta   = $signed(shifted[COEF_W:0]);
    end

    // Add or subtract the offset, then clamp to the signed range.
    always_comb begin
        sum = add ? (SUM_W'(coef) + SUM_W'(delta)) : (SUM_W'(coef) - SUM_W'(delta));
        if (sum > MAX_S)      res = MAX_S[COEF_W-1:0];
        else if (sum < MIN_S) res = MIN_S[COEF_W-1:0];
        else                  res = sum[COEF_W-1:0];
    end

endmodule

// File: rtl/wm_inserter.sv
// Module: wm_inserter (top)
// Embeds a 2x2 watermark tile into the four low-frequency DCT coefficients of
// one block. PARALLEL=0 uses one lane (4 cycles per block); PARALLEL=1 uses
// two lanes (2 cycles). Inputs are captured at an accepted start. Results
// are valid while done_o is high.
module wm_inserter
    import wm_pkg::*;
#(
    parameter int unsigned COEF_W   = 16,
    parameter int unsigned ALPHA_W  = 16,
    parameter int unsigned FRAC_W   = 15,
    parameter int unsigned ALPHA_DC = 655,
    parameter int unsigned ALPHA_AC = 3277,
    parameter bit          PARALLEL = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [COEF_W-1:0] c00_i,
    input  logic signed [COEF_W-1:0] c01_i,
    input  logic signed [COEF_W-1:0] c10_i,
    input  logic signed [COEF_W-1:0] c11_i,
    input  logic [NUM_COEF-1:0]      wm_i,
    output logic signed [COEF_W-1:0] c00_o,
    output logic signed [COEF_W-1:0] c01_o,
    output logic signed [COEF_W-1:0] c10_o,
    output logic signed [COEF_W-1:0] c11_o,
    output logic                     done_o
);

    localparam int unsigned LANES  = PARALLEL ? 2 : 1;
    localparam int unsigned STEPS  = NUM_COEF / LANES;
    localparam int unsigned STEP_W = $clog2(STEPS);

    logic                     accept, busy, last;
    logic [STEP_W-1:0]        step;
    logic signed [COEF_W-1:0] coef_q [NUM_COEF];
    logic [NUM_COEF-1:0]      wm_q;
    logic signed [COEF_W-1:0] res_q  [NUM_COEF];
    logic [IDX_W-1:0]         lane_idx [LANES];
    logic signed [COEF_W-1:0] lane_res [LANES];

    wm_seq #(.STEPS(STEPS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .last   (last),
        .step   (step),
        .done   (done_o)
    );

    // Capture the coefficient set and tile bits when a block is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= '0;
            wm_q <= '0;
        end else if (accept) begin
            coef_q[0] <= c00_i;
            coef_q[1] <= c01_i;
            coef_q[2] <= c10_i;
            coef_q[3] <= c11_i;
            wm_q      <= wm_i;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ALPHA_W-1:0] alpha;

        // Coefficient index handled by this lane in the current step.
        assign lane_idx[g] = IDX_W'(int'(step) * LANES + g);

        wm_strength_sel #(
            .ALPHA_W  (ALPHA_W),
            .ALPHA_DC (ALPHA_DC),
            .ALPHA_AC (ALPHA_AC)
        ) u_sel (
            .idx   (lane_idx[g]),
            .alpha (alpha)
        );

        wm_scale_lane #(
            .COEF_W  (COEF_W),
            .ALPHA_W (ALPHA_W),
            .FRAC_W  (FRAC_W)
        ) u_lane (
            .coef  (coef_q[lane_idx[g]]),
            .alpha (alpha),
            .add   (wm_q[lane_idx[g]]),
            .res   (lane_res[g])
        );
    end

    // Write each lane's result into its coefficient slot during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_COEF; i++) res_q[i] <= '0;
        end else if (busy) begin
            for (int l = 0; l < LANES; l++) res_q[lane_idx[l]] <= lane_res[l];
        end
    end

    assign c00_o = res_q[0];
    assign c01_o = res_q[1];
    assign c10_o = res_q[2];
    assign c11_o = res_q[3];

endmodule

// File: rtl/wm_inserter_chk.sv
// Module: wm_inserter_chk
// Protocol checker bound into wm_inserter. It covers strobe shape and
// latency, start handling during a run, and output holding while idle.
module wm_inserter_chk #(
    parameter int unsigned STEPS  = 4,
    parameter int unsigned COEF_W = 16,
    localparam int unsigned STEP_W = $clog2(STEPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              last,
    input logic [STEP_W-1:0] step,
    input logic              done_o,
    input logic [COEF_W-1:0] c00_o,
    input logic [COEF_W-1:0] c01_o,
    input logic [COEF_W-1:0] c10_o,
    input logic [COEF_W-1:0] c11_o
);

    logic [7:0] run_cnt;

    // Count the cycles since the most recent accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_cnt <= '0;
        else if (start && (!busy || last))   run_cnt <= 8'd1;
        else if (busy && run_cnt != 8'hFF)   run_cnt <= run_cnt + 8'd1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(run_cnt) == 8'(STEPS))); // R6
    AST_IGNORE_MIDRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && start) |=> (busy && step == $past(step) + 1'b1)); // R7
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (last && start) |=> (busy && step == '0)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(c00_o) && $stable(c01_o) && $stable(c10_o) && $stable(c11_o))); // R8

endmodule

bind wm_inserter wm_inserter_chk #(.STEPS(STEPS), .COEF_W(COEF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .last   (last),
    .step   (step),
    .done_o (done_o),
    .c00_o  (c00_o),
    .c01_o  (c01_o),
    .c10_o  (c10_o),
    .c11_o  (c11_o)
);

// File: tb/wm_inserter_tb.sv
// Bench for wm_inserter: runs both variants side by side on shared data,
// with directed corners and seeded random blocks checked against a model.
module wm_inserter_tb;

    typedef logic signed [15:0] coef4_t [4];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_a = 1'b0;
    logic       start_p = 1'b0;
    coef4_t     cin;
    logic [3:0] wm_in = 4'h0;
    coef4_t     oa, op;
    logic       done_a, done_p;
    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    wm_inserter #(.PARALLEL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start_a),
        .c00_i(cin[0]), .c01_i(cin[1]), .c10_i(cin[2]), .c11_i(cin[3]), .wm_i(wm_in),
        .c00_o(oa[0]), .c01_o(oa[1]), .c10_o(oa[2]), .c11_o(oa[3]), .done_o(done_a)
    );

    wm_inserter #(.PARALLEL(1'b1)) u_dut_par (
        .clk(clk), .rst_n(rst_n), .start(start_p),
        .c00_i(cin[0]), .c01_i(cin[1]), .c10_i(cin[2]), .c11_i(cin[3]), .wm_i(wm_in),
        .c00_o(op[0]), .c01_o(op[1]), .c10_o(op[2]), .c11_o(op[3]), .done_o(done_p)
    );

    // Reference model: strength by index, rounded offset, sign by bit, clamp.
    function automatic logic signed [15:0] model(longint c, bit b, int idx);
        longint a = (idx == 0) ? 655 : 3277;
        longint d = (c * a + 16384) >>> 15;
        longint s = b ? c + d : c - d;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return 16'(s);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic get_done(bit par);
        return par ? done_p : done_a;
    endfunction

    function automatic logic signed [15:0] get_out(bit par, int i);
        return par ? op[i] : oa[i];
    endfunction

    task automatic set_start(bit par, bit v);
        if (par) start_p = v;
        else     start_a = v;
    endtask

    task automatic scramble();
        for (int i = 0; i < 4; i++) cin[i] = 16'($urandom);
        wm_in = 4'($urandom);
    endtask

    task automatic expect_outs(bit par, coef4_t e, string req);
        for (int i = 0; i < 4; i++) chk(req, $sformatf("par=%0d coef%0d", par, i), get_out(par, i), e[i]);
    endtask

    function automatic coef4_t expected(coef4_t c, logic [3:0] w);
        coef4_t e;
        for (int i = 0; i < 4; i++) e[i] = model(c[i], w[i], i);
        return e;
    endfunction

    // One block; inputs are scrambled after the accepting edge (R9).
    task automatic block_test(bit par, coef4_t c, logic [3:0] w, string req);
        coef4_t e = expected(c, w);
        int     lat = par ? 2 : 4;
        bit     early = 1'b0;
        @(negedge clk); cin = c; wm_in = w; set_start(par, 1'b1);
        @(negedge clk); set_start(par, 1'b0); scramble();
        for (int j = 1; j < lat; j++) begin
            @(negedge clk);
            if (get_done(par)) early = 1'b1;
            scramble();
        end
        @(negedge clk);
        chk("R6", "done before latency", early, 0);
        chk("R6", "done at latency", get_done(par), 1);
        expect_outs(par, e, req);
        repeat (3) begin @(negedge clk); scramble(); end
        chk("R6", "done single pulse", get_done(par), 0);
        expect_outs(par, e, "R8 hold");
    endtask

    // New start in the final compute cycle: both blocks complete in turn.
    task automatic back_to_back(bit par);
        coef4_t ca, cb, ea, eb;
        logic [3:0] wa, wb;
        int lat = par ? 2 : 4;
        bit extra = 1'b0;
        for (int i = 0; i < 4; i++) begin ca[i] = 16'($urandom); cb[i] = 16'($urandom); end
        wa = 4'b1001; wb = 4'b0110;
        ea = expected(ca, wa); eb = expected(cb, wb);
        @(negedge clk); cin = ca; wm_in = wa; set_start(par, 1'b1);
        @(negedge clk); set_start(par, 1'b0); scramble();
        for (int j = 1; j < lat - 1; j++) begin @(negedge clk); scramble(); end
        @(negedge clk); cin = cb; wm_in = wb; set_start(par, 1'b1);
        @(negedge clk); set_start(par, 1'b0);
        chk("R7", "first done in overlap", get_done(par), 1);
        expect_outs(par, ea, "R7 first block");
        scramble();
        for (int j = 1; j < lat; j++) begin
            @(negedge clk);
            if (get_done(par)) extra = 1'b1;
            scramble();
        end
        @(negedge clk);
        chk("R7", "no done between blocks", extra, 0);
        chk("R7", "second done back to back", get_done(par), 1);
        expect_outs(par, eb, "R7 second block");
    endtask

    // Start at step 1 of a compact run must be dropped.
    task automatic ignored_start();
        coef4_t ca, cb, ea;
        logic [3:0] wa;
        bit extra = 1'b0;
        for (int i = 0; i < 4; i++) begin ca[i] = 16'($urandom); cb[i] = 16'($urandom); end
        wa = 4'b0011;
        ea = expected(ca, wa);
        @(negedge clk); cin = ca; wm_in = wa; start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        @(negedge clk); cin = cb; wm_in = ~wa; start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "done for original block", done_a, 1);
        expect_outs(1'b0, ea, "R7 ignored start");
        repeat (6) begin
            @(negedge clk);
            if (done_a) extra = 1'b1;
        end
        chk("R7", "no done from ignored start", extra, 0);
        expect_outs(1'b0, ea, "R7 R8 outputs kept");
    endtask

    initial begin
        coef4_t c;
        void'($urandom(32'd24681357));
        for (int i = 0; i < 4; i++) cin[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset done compact", done_a, 0);
        chk("R1", "reset done parallel", done_p, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R1", "reset out compact", oa[i], 0);
            chk("R1", "reset out parallel", op[i], 0);
        end
        rst_n = 1'b1;

        for (int p = 0; p < 2; p++) begin
            bit par = p[0];
            c = '{16'sd0, 16'sd0, 16'sd0, 16'sd0};
            block_test(par, c, 4'b1111, "R3 zero");
            c = '{16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767};
            block_test(par, c, 4'b1111, "R5 max add");
            block_test(par, c, 4'b0000, "R3 max sub");
            c = '{-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768};
            block_test(par, c, 4'b1111, "R5 min add");
            block_test(par, c, 4'b0000, "R3 min sub");
            c = '{16'sd10000, 16'sd10000, 16'sd10000, 16'sd10000};
            block_test(par, c, 4'b0101, "R2 R4 pattern");
            c = '{-16'sd1234, 16'sd777, -16'sd5, 16'sd31000};
            block_test(par, c, 4'b1010, "R2 R3 mixed");
            for (int n = 0; n < 25; n++) begin
                for (int i = 0; i < 4; i++) c[i] = 16'($urandom);
                block_test(par, c, 4'($urandom), "R3 R9 random");
            end
            back_to_back(par);
        end

        // Strength values checked against hand-worked numbers (R4).
        c = '{16'sd10000, 16'sd10000, 16'sd10000, 16'sd10000};
        block_test(1'b0, c, 4'b1111, "R4 all add");
        chk("R4", "c00 strength value", oa[0], 10200);
        chk("R4", "c01 strength value", oa[1], 11000);

        ignored_start();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule